// File: doc/BRIEF.md
# USB Device Interrupt Event Controller

This block gathers the event strobes that a USB device core raises for each endpoint and for the bus as a whole. It keeps each event in a sticky status flag until firmware clears it. The enabled flags are then merged into one interrupt request line for the CPU. Per-endpoint events are IN acknowledged, OUT stored in bank 0, OUT stored in bank 1, SETUP received and STALL sent. Global events are start of frame, suspend and resume. The block also keeps a suspended-state bit, so that a resume raises the wake-up flag only when the bus really was asleep.

Firmware reaches the block through a small register port. Each write takes one cycle, and reads are combinational. Writing 0 to a status bit clears that bit; writing 1 to it has no effect. Per-endpoint parameters decide which endpoints have a second OUT bank (ping-pong) and which are isochronous. An isochronous endpoint has no stall flag. A two-bit priority register drives a priority output next to the request line.

Register map (5-bit address, 8-bit data):
- 0x00: global status.
- 0x01: global enables.
- 0x02: per-endpoint enables.
- 0x03: endpoint pending summary.
- 0x04: priority.
- 0x08+i: status of endpoint i.
- 0x10+i: flag enables of endpoint i.

Top module: `usb_irq_ctrl`

## Requirements
- R1: An IN-acknowledged strobe on endpoint i sets bit 0 of register 0x08+i on the next clock edge.
- R2: An OUT-bank-0 strobe sets bit 1 of 0x08+i. An OUT-bank-1 strobe sets bit 2, but only on ping-pong endpoints (endpoints 1 and 3 by default). On any other endpoint, bit 2 always reads 0.
- R3: A SETUP strobe sets bit 3 of 0x08+i.
- R4: A STALL-sent strobe sets bit 4 of 0x08+i, but only on non-isochronous endpoints (endpoint 2 is isochronous by default). On an isochronous endpoint, bit 4 always reads 0.
- R5: A SETUP strobe clears bit 4 of that endpoint, unless a STALL-sent strobe arrives in the same cycle. In that case bit 4 ends up set.
- R6: Every status flag stays set until firmware writes 0 to it. Writing 1 leaves the flag unchanged. If a hardware set and a firmware clear hit the same flag in the same cycle, the flag ends up set.
- R7: In register 0x00, a start-of-frame strobe sets bit 0 and a suspend strobe sets bit 1. Bit 3 is the read-only suspended state: a suspend strobe sets it and a resume strobe clears it.
- R8: In register 0x00, a resume strobe sets the wake-up flag (bit 2) only while the suspended state is 1. A resume strobe at any other time changes nothing.
- R9: irq_o is 1 when either of these holds:
  - some endpoint flag is set, its flag-enable bit in 0x10+i is set, the endpoint's bit i in 0x02 is set, and the global endpoint enable (bit 3 of 0x01) is set;
  - a global flag in bits 2:0 of 0x00 is set and the matching bit of 0x01 is set.
- R10: Bit i of register 0x03 is 1 when endpoint i has a set flag whose flag-enable bit is set and its bit in 0x02 is set. The global endpoint enable does not affect this bit.
- R11: Bits 1:0 of register 0x04 drive prio_o. The values 00, 01, 10 and 11 mean levels 0 (lowest), 1, 2 and 3 (highest).
- R12: After reset, all registers read 0, irq_o is 0 and prio_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_ack_i | input | N_EP | IN packet acknowledged, one strobe per endpoint |
| out_b0_i | input | N_EP | OUT packet stored in bank 0 |
| out_b1_i | input | N_EP | OUT packet stored in bank 1 |
| setup_i | input | N_EP | SETUP packet received |
| stall_sent_i | input | N_EP | STALL handshake sent |
| sof_i | input | 1 | Start of frame received |
| suspend_i | input | 1 | Bus suspend detected |
| resume_i | input | 1 | Bus resume detected |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Combined interrupt request |
| prio_o | output | 2 | Priority level of the request |

## Verification
The bench drives every event into every endpoint and compares the result against the ping-pong and isochronous layout.
- A design that ignored that layout would show a bank-1 flag on a single-bank endpoint, or a stall flag on the isochronous one.

It also targets these corner cases:
- SETUP and STALL-sent in the same cycle: a design that let the clear win here would drop a stall it had just reported.
- A hardware set in the same cycle as a firmware clear: a design that let the clear win would lose an event.
- A resume while the bus is awake: a design that did not check the suspended state would raise a false wake-up.

Finally, the bench walks all eight combinations of the three enable levels for each endpoint. This catches a request line or summary bit that skips a gate or ignores the global enable.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int FLAG_W = 5;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int GLB_W  = 3;

  localparam logic [ADDR_W-1:0] A_GSTAT  = 5'h00;
  localparam logic [ADDR_W-1:0] A_GEN    = 5'h01;
  localparam logic [ADDR_W-1:0] A_EPEN   = 5'h02;
  localparam logic [ADDR_W-1:0] A_EPPEND = 5'h03;
  localparam logic [ADDR_W-1:0] A_PRIO   = 5'h04;
  localparam logic [ADDR_W-1:0] A_EPSTAT = 5'h08;
  localparam logic [ADDR_W-1:0] A_EPFEN  = 5'h10;

  typedef struct packed {
    logic stall;
    logic setup;
    logic rxo1;
    logic rxo0;
    logic txc;
  } ep_ev_t;
endpackage

// File: rtl/usb_ep_flags.sv
module usb_ep_flags
  import usb_irq_pkg::*;
#(
  parameter bit PINGPONG = 1'b0,
  parameter bit ISO      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ep_ev_t            ev_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [FLAG_W-1:0] PRESENT = {!ISO, 1'b1, PINGPONG, 1'b1, 1'b1};

  logic [FLAG_W-1:0] ev_vec;
  logic [FLAG_W-1:0] hw_clr;

  assign ev_vec = ev_i;
  // setup auto-clears the stall flag
  assign hw_clr = {ev_i.setup, {(FLAG_W-1){1'b0}}};

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    if (PRESENT[k]) begin : g_on
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= ev_vec[k] | (q & ~clr_i[k] & ~hw_clr[k]);
      end
      assign flags_o[k] = q;
    end else begin : g_off
      assign flags_o[k] = 1'b0;
    end
  end

  AST_TXC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.txc |=> flags_o[0]); // R1

  AST_SETUP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.setup |=> flags_o[3]); // R3

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.rxo0 && clr_i[1]) |=> flags_o[1]); // R6

  if (!ISO) begin : g_stall_chk
    AST_STALL_AUTOCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i.setup && !ev_i.stall) |=> !flags_o[4]); // R5
  end
endmodule

// File: rtl/usb_glb_flags.sv
module usb_glb_flags
  import usb_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  input  logic [GLB_W-1:0] clr_i,
  output logic [GLB_W-1:0] flags_o,
  output logic             susp_state_o
);
  logic             state_q;
  logic [GLB_W-1:0] flags_q;
  logic [GLB_W-1:0] set;

  // wake-up only counts when the bus was asleep
  assign set = {resume_i & state_q, suspend_i, sof_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      flags_q <= '0;
    end else begin
      if (suspend_i)     state_q <= 1'b1;
      else if (resume_i) state_q <= 1'b0;
      flags_q <= set | (flags_q & ~clr_i);
    end
  end

  assign flags_o      = flags_q;
  assign susp_state_o = state_q;

  AST_SUSP_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> susp_state_o); // R7

  AST_WAKE_NEEDS_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !susp_state_o) |=> !$rose(flags_o[2])); // R8

  AST_RESUME_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !susp_state_o && !suspend_i) |=> !susp_state_o); // R8
endmodule

// File: rtl/usb_irq_combine.sv
module usb_irq_combine
  import usb_irq_pkg::*;
#(
  parameter int N_EP = 4
) (
  input  logic [N_EP-1:0][FLAG_W-1:0] ep_flags_i,
  input  logic [N_EP-1:0][FLAG_W-1:0] ep_flag_en_i,
  input  logic [N_EP-1:0]             ep_en_i,
  input  logic                        ep_glb_en_i,
  input  logic [GLB_W-1:0]            glb_flags_i,
  input  logic [GLB_W-1:0]            glb_en_i,
  output logic [N_EP-1:0]             ep_pend_o,
  output logic                        irq_o
);
  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    assign ep_pend_o[i] = ep_en_i[i] & |(ep_flags_i[i] & ep_flag_en_i[i]);
  end

  assign irq_o = (ep_glb_en_i & |ep_pend_o) | |(glb_flags_i & glb_en_i);
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int              N_EP        = 4,
  parameter logic [N_EP-1:0] EP_PINGPONG = 4'b1010,
  parameter logic [N_EP-1:0] EP_ISO      = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EP-1:0]   in_ack_i,
  input  logic [N_EP-1:0]   out_b0_i,
  input  logic [N_EP-1:0]   out_b1_i,
  input  logic [N_EP-1:0]   setup_i,
  input  logic [N_EP-1:0]   stall_sent_i,
  input  logic              sof_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [1:0]        prio_o
);
  localparam int PAD_EP = DATA_W - FLAG_W;
  localparam int PAD_N  = DATA_W - N_EP;

  logic [N_EP-1:0][FLAG_W-1:0] ep_flags, ep_clr, ep_fen_q;
  logic [N_EP-1:0]             ep_en_q, ep_pend;
  logic [GLB_W:0]              gen_q;
  logic [GLB_W-1:0]            g_flags, g_clr;
  logic                        susp_state;
  logic [1:0]                  prio_q;

  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    ep_ev_t ev;
    assign ev.txc   = in_ack_i[i];
    assign ev.rxo0  = out_b0_i[i];
    assign ev.rxo1  = out_b1_i[i];
    assign ev.setup = setup_i[i];
    assign ev.stall = stall_sent_i[i];

    usb_ep_flags #(.PINGPONG(EP_PINGPONG[i]), .ISO(EP_ISO[i])) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ev_i    (ev),
      .clr_i   (ep_clr[i]),
      .flags_o (ep_flags[i])
    );
  end

  usb_glb_flags u_glb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof_i),
    .suspend_i    (suspend_i),
    .resume_i     (resume_i),
    .clr_i        (g_clr),
    .flags_o      (g_flags),
    .susp_state_o (susp_state)
  );

  usb_irq_combine #(.N_EP(N_EP)) u_comb (
    .ep_flags_i   (ep_flags),
    .ep_flag_en_i (ep_fen_q),
    .ep_en_i      (ep_en_q),
    .ep_glb_en_i  (gen_q[GLB_W]),
    .glb_flags_i  (g_flags),
    .glb_en_i     (gen_q[GLB_W-1:0]),
    .ep_pend_o    (ep_pend),
    .irq_o        (irq_o)
  );

  // write-0-to-clear decode
  always_comb begin
    g_clr = '0;
    if (reg_we_i && reg_addr_i == A_GSTAT) g_clr = ~reg_wdata_i[GLB_W-1:0];
    for (int i = 0; i < N_EP; i++) begin
      ep_clr[i] = '0;
      if (reg_we_i && reg_addr_i == A_EPSTAT + ADDR_W'(i))
        ep_clr[i] = ~reg_wdata_i[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q    <= '0;
      ep_en_q  <= '0;
      ep_fen_q <= '0;
      prio_q   <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_GEN)  gen_q   <= reg_wdata_i[GLB_W:0];
      if (reg_addr_i == A_EPEN) ep_en_q <= reg_wdata_i[N_EP-1:0];
      if (reg_addr_i == A_PRIO) prio_q  <= reg_wdata_i[1:0];
      for (int i = 0; i < N_EP; i++)
        if (reg_addr_i == A_EPFEN + ADDR_W'(i)) ep_fen_q[i] <= reg_wdata_i[FLAG_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_GSTAT:  reg_rdata_o = {{(DATA_W-GLB_W-1){1'b0}}, susp_state, g_flags};
      A_GEN:    reg_rdata_o = {{(DATA_W-GLB_W-1){1'b0}}, gen_q};
      A_EPEN:   reg_rdata_o = {{PAD_N{1'b0}}, ep_en_q};
      A_EPPEND: reg_rdata_o = {{PAD_N{1'b0}}, ep_pend};
      A_PRIO:   reg_rdata_o = {6'b0, prio_q};
      default:  reg_rdata_o = '0;
    endcase
    for (int i = 0; i < N_EP; i++) begin
      if (reg_addr_i == A_EPSTAT + ADDR_W'(i)) reg_rdata_o = {{PAD_EP{1'b0}}, ep_flags[i]};
      if (reg_addr_i == A_EPFEN + ADDR_W'(i))  reg_rdata_o = {{PAD_EP{1'b0}}, ep_fen_q[i]};
    end
  end

  assign prio_o = prio_q;

  AST_PRIO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_PRIO) |=> prio_o == $past(reg_wdata_i[1:0])); // R11

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_q == '0) |-> !irq_o); // R9
endmodule

// File: tb/usb_irq_ctrl_bench.sv
`timescale 1ns/1ps
module usb_irq_ctrl_bench;
  localparam int NE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] in_ack = '0, ob0 = '0, ob1 = '0, setup = '0, stall = '0;
  logic sof = 1'b0, susp = 1'b0, resm = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  logic [1:0] prio;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  usb_irq_ctrl u_usb_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .in_ack_i(in_ack), .out_b0_i(ob0), .out_b1_i(ob1),
    .setup_i(setup), .stall_sent_i(stall),
    .sof_i(sof), .suspend_i(susp), .resume_i(resm),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .prio_o(prio)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_ev(input int e, input int f, input logic v);
    case (f)
      0: in_ack[e] = v;
      1: ob0[e]    = v;
      2: ob1[e]    = v;
      3: setup[e]  = v;
      default: stall[e] = v;
    endcase
  endtask

  task automatic pulse(input int e, input int f);
    @(negedge clk); set_ev(e, f, 1'b1);
    @(negedge clk); set_ev(e, f, 1'b0);
  endtask

  function automatic bit present(input int e, input int f);
    if (f == 2) return (e == 1 || e == 3);
    if (f == 4) return (e != 2);
    return 1'b1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d); chk("R12 reset reg", int'(d), 0);
    end
    chk("R12 irq", int'(irq), 0);
    chk("R12 prio", int'(prio), 0);

    // R1 R2 R3 R4 R6 per-endpoint event sweep
    for (int e = 0; e < NE; e++) begin
      for (int f = 0; f < 5; f++) begin
        int exp;
        exp = present(e, f) ? (1 << f) : 0;
        pulse(e, f);
        rd(5'(8 + e), d);
        chk(f == 0 ? "R1 txc" : f < 3 ? "R2 out bank" : f == 3 ? "R3 setup" : "R4 stall",
            int'(d), exp);
        wr(5'(8 + e), 8'hFF);
        rd(5'(8 + e), d); chk("R6 write-1 no effect", int'(d), exp);
        wr(5'(8 + e), 8'h00);
        rd(5'(8 + e), d); chk("R6 write-0 clears", int'(d), 0);
      end
    end

    // R6 set wins over same-cycle clear
    pulse(0, 1);
    @(negedge clk); in_ack[0] = 1'b1; we = 1'b1; addr = 5'h08; wdata = 8'h00;
    @(negedge clk); in_ack[0] = 1'b0; we = 1'b0;
    rd(5'h08, d); chk("R6 set wins", int'(d), 8'h01);
    wr(5'h08, 8'h00);

    // R5 setup clears stall, unless concurrent stall
    pulse(0, 4);
    rd(5'h08, d); chk("R4 stall set", int'(d), 8'h10);
    pulse(0, 3);
    rd(5'h08, d); chk("R5 setup clears stall", int'(d), 8'h08);
    wr(5'h08, 8'h00);
    @(negedge clk); setup[1] = 1'b1; stall[1] = 1'b1;
    @(negedge clk); setup[1] = 1'b0; stall[1] = 1'b0;
    rd(5'h09, d); chk("R5 concurrent stall kept", int'(d), 8'h18);
    wr(5'h09, 8'h00);

    // R9 R10 enable gating sweep
    for (int e = 0; e < NE; e++) begin
      pulse(e, 0);
      for (int c = 0; c < 8; c++) begin
        int g, p, f;
        g = c & 1; p = (c >> 1) & 1; f = (c >> 2) & 1;
        wr(5'h01, 8'(g << 3));
        wr(5'h02, 8'(p << e));
        wr(5'(16 + e), 8'(f));
        @(negedge clk);
        chk("R9 irq gating", int'(irq), g & p & f);
        rd(5'h03, d); chk("R10 summary", int'(d), (p & f) << e);
      end
      wr(5'(16 + e), 8'h1E);
      wr(5'h01, 8'h08); wr(5'h02, 8'h0F);
      @(negedge clk); chk("R9 other flag enable", int'(irq), 0);
      wr(5'(16 + e), 8'h00); wr(5'h01, 8'h00); wr(5'h02, 8'h00);
      wr(5'(8 + e), 8'h00);
    end

    // R7 R8 global flags
    @(negedge clk); sof = 1'b1; @(negedge clk); sof = 1'b0;
    rd(5'h00, d); chk("R7 sof", int'(d), 8'h01);
    wr(5'h01, 8'h01); @(negedge clk); chk("R9 sof irq", int'(irq), 1);
    wr(5'h00, 8'h00); @(negedge clk); chk("R9 sof cleared irq", int'(irq), 0);
    wr(5'h01, 8'h00);
    @(negedge clk); resm = 1'b1; @(negedge clk); resm = 1'b0;
    rd(5'h00, d); chk("R8 resume ignored", int'(d), 8'h00);
    @(negedge clk); susp = 1'b1; @(negedge clk); susp = 1'b0;
    rd(5'h00, d); chk("R7 suspend", int'(d), 8'h0A);
    @(negedge clk); resm = 1'b1; @(negedge clk); resm = 1'b0;
    rd(5'h00, d); chk("R8 wake", int'(d), 8'h06);
    wr(5'h01, 8'h04); @(negedge clk); chk("R9 wake irq", int'(irq), 1);
    wr(5'h00, 8'h00);
    rd(5'h00, d); chk("R6 global clear", int'(d), 8'h00);
    wr(5'h01, 8'h00);

    // R11 priority encoding
    for (int p = 0; p < 4; p++) begin
      wr(5'h04, 8'(p));
      @(negedge clk); chk("R11 prio_o", int'(prio), p);
      rd(5'h04, d); chk("R11 prio reg", int'(d), p);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule